// File: doc/BRIEF.md
# Peripheral interrupt priority resolver

This block keeps a small bank of priority registers for twenty interrupt sources and picks which pending request the CPU should see next. Five 16-bit registers sit behind a plain synchronous bus. Each register holds four 4-bit level fields, and each field belongs to exactly one source. On every clock the resolver compares the pending request lines against the programmed levels and against the CPU's current mask level. It registers the winner as a source index, a level and a valid flag.

Software programs a level from 1 to 15 for each source it wants to hear from. Level 0 turns a source off. A source is forwarded only when its level is strictly above the CPU mask. Several reset and standby inputs control what happens to the stored levels. Power-on reset, manual reset and hardware standby wipe the levels. Software standby freezes the block and keeps its contents.

Top module: `prio_resolver`

## Requirements
- R1: Bus addresses 0 to 4 select five 16-bit read/write registers. Source index s (0 to 19) takes its level from register s/4, in the nibble at bits [15-4*(s%4) -: 4]. Index 0 is therefore register 0 bits 15:12.
- R2: Some nibbles are reserved: register 1 bits 3:0, register 3 bits 15:8, and register 4 bits 11:8. They always read as 0, and writes to them are dropped.
- R3: Addresses 5 to 7 read as 0, and writes to them change no register.
- R4: A low `por_n` clears all registers and outputs at once. A high `man_rst` or `hw_stby` at a clock edge clears all registers and outputs at that edge.
- R5: While `sw_stby` is high and no clear is active, the registers and the outputs hold their values, and bus writes are ignored. The registers are not cleared.
- R6: A source whose level is 0 never wins, even when its request is high.
- R7: A request is forwarded only when its level is strictly greater than `cpu_mask`.
- R8: Among forwarded requests, the highest level wins. Equal levels go to the lower source index.
- R9: The outputs are registered. They reflect the requests, mask and levels present before the previous clock edge. When nothing qualifies, `irq_valid`, `irq_src` and `irq_lvl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous clear |
| hw_stby | input | 1 | Hardware standby, synchronous clear |
| sw_stby | input | 1 | Software standby, freezes state |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| req | input | 20 | Pending request per source |
| cpu_mask | input | 4 | CPU mask level |
| irq_valid | output | 1 | A request is forwarded |
| irq_src | output | 5 | Winning source index |
| irq_lvl | output | 4 | Winning level |

## Verification
Several properties are checked on every cycle:
- Reserved nibbles and unmapped addresses read as zero.
- A valid output never carries level 0.
- The registered outputs follow the combinational winner one edge later.
- A clear empties both the bank and the outputs.
- Software standby leaves them unchanged.

Other behaviour is shown only by the bench's scenarios, which compare results against an independent model. This covers:
- the field-to-source mapping;
- tie breaking by index;
- the strict comparison against the mask;
- the asynchronous effect of the power-on reset in the middle of a cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_REGS  = 5;
  localparam int FLDS_PER  = 4;
  localparam int LVL_W     = 4;
  localparam int DATA_W    = FLDS_PER * LVL_W;
  localparam int NUM_SRC   = NUM_REGS * FLDS_PER;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int ADDR_W    = 3;

  // Bits of register r that hold a real field; reserved nibbles are 0.
  function automatic logic [DATA_W-1:0] live_bits(input int r);
    case (r)
      1:       live_bits = 16'hFFF0;
      3:       live_bits = 16'h00FF;
      4:       live_bits = 16'hF0FF;
      default: live_bits = 16'hFFFF;
    endcase
  endfunction

  // Bit offset of the field owned by position p (0 = top nibble).
  function automatic int fld_lsb(input int p);
    fld_lsb = (FLDS_PER - 1 - p) * LVL_W;
  endfunction
endpackage

// File: rtl/prio_regfile.sv
module prio_regfile
  import irq_prio_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr_sync,
  input  logic             hold,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NREG*DW-1:0] bank
);
  logic [NREG-1:0] sel;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [DW-1:0] KEEP = live_bits(r);
    logic [DW-1:0] q;
    assign sel[r] = (addr == AW'(r));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    q <= '0;
      else if (clr_sync)             q <= '0;
      else if (we && sel[r] && !hold) q <= wdata & KEEP;
    end
    assign bank[r*DW +: DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++)
      if (sel[r]) rdata = bank[r*DW +: DW];
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NSRC = 20,
  parameter int LW   = 4,
  parameter int SW   = 5
) (
  input  logic [NSRC*LW-1:0] lvls,
  input  logic [NSRC-1:0]    req,
  input  logic [LW-1:0]      mask,
  output logic               found,
  output logic [SW-1:0]      src,
  output logic [LW-1:0]      lvl
);
  logic [LW-1:0] best;

  // Threshold starts at the mask; strict compare masks level 0 and
  // keeps the lowest index on a tie.
  always_comb begin
    best  = mask;
    found = 1'b0;
    src   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (lvls[i*LW +: LW] > best)) begin
        best  = lvls[i*LW +: LW];
        src   = SW'(i);
        found = 1'b1;
      end
    end
    lvl = found ? best : '0;
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int NFLD = FLDS_PER,
  parameter int LW   = LVL_W,
  parameter int AW   = ADDR_W,
  localparam int DW  = NFLD * LW,
  localparam int NS  = NREG * NFLD,
  localparam int SW  = $clog2(NS)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          man_rst,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NS-1:0] req,
  input  logic [LW-1:0] cpu_mask,
  output logic          irq_valid,
  output logic [SW-1:0] irq_src,
  output logic [LW-1:0] irq_lvl
);
  logic               clr_sync;
  logic [NREG*DW-1:0] reg_bank;
  logic [NS*LW-1:0]   src_lvls;
  logic               win_valid_c;
  logic [SW-1:0]      win_src_c;
  logic [LW-1:0]      win_lvl_c;

  assign clr_sync = man_rst | hw_stby;

  prio_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .por_n(por_n), .clr_sync(clr_sync), .hold(sw_stby),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rdata(bus_rdata), .bank(reg_bank)
  );

  for (genvar s = 0; s < NS; s++) begin : g_map
    assign src_lvls[s*LW +: LW] =
      reg_bank[(s / NFLD)*DW + (NFLD - 1 - (s % NFLD))*LW +: LW];
  end

  prio_arbiter #(.NSRC(NS), .LW(LW), .SW(SW)) u_arb (
    .lvls(src_lvls), .req(req), .mask(cpu_mask),
    .found(win_valid_c), .src(win_src_c), .lvl(win_lvl_c)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      irq_valid <= 1'b0;
      irq_src   <= '0;
      irq_lvl   <= '0;
    end else if (clr_sync) begin
      irq_valid <= 1'b0;
      irq_src   <= '0;
      irq_lvl   <= '0;
    end else if (!sw_stby) begin
      irq_valid <= win_valid_c;
      irq_src   <= win_src_c;
      irq_lvl   <= win_lvl_c;
    end
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NREG = 5,
  parameter int DW   = 16,
  parameter int AW   = 3,
  parameter int SW   = 5,
  parameter int LW   = 4
) (
  input logic               clk,
  input logic               por_n,
  input logic               man_rst,
  input logic               hw_stby,
  input logic               sw_stby,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_rdata,
  input logic [NREG*DW-1:0] reg_bank,
  input logic               win_valid_c,
  input logic [SW-1:0]      win_src_c,
  input logic [LW-1:0]      win_lvl_c,
  input logic               irq_valid,
  input logic [SW-1:0]      irq_src,
  input logic [LW-1:0]      irq_lvl
);
  p_rsv_b_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == AW'(1)) |-> (bus_rdata[3:0] == 4'h0));
  p_rsv_d_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == AW'(3)) |-> (bus_rdata[15:8] == 8'h00));
  p_rsv_e_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == AW'(4)) |-> (bus_rdata[11:8] == 4'h0));
  p_unmapped_r3: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr >= AW'(NREG)) |-> (bus_rdata == '0));
  p_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
    (man_rst || hw_stby) |=> (!irq_valid && reg_bank == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && !man_rst && !hw_stby) |=>
      ($stable(reg_bank) && $stable(irq_valid) && $stable(irq_src) && $stable(irq_lvl)));
  p_no_zero_r6: assert property (@(posedge clk) disable iff (!por_n)
    irq_valid |-> (irq_lvl != '0));
  p_follow_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!sw_stby && !man_rst && !hw_stby) |=>
      (irq_valid == $past(win_valid_c) && irq_src == $past(win_src_c)
       && irq_lvl == $past(win_lvl_c)));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    !irq_valid |-> (irq_src == '0 && irq_lvl == '0));
endmodule

bind prio_resolver prio_resolver_chk #(
  .NREG(NREG), .DW(DW), .AW(AW), .SW(SW), .LW(LW)
) u_chk (.*);

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
  logic        clk = 1'b0;
  logic        por_n, man_rst, hw_stby, sw_stby;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata, bus_rdata;
  logic [19:0] req;
  logic [3:0]  cpu_mask;
  logic        irq_valid;
  logic [4:0]  irq_src;
  logic [3:0]  irq_lvl;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] mdl [5];

  always #10 clk = ~clk;

  prio_resolver dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // Storage rule restated per register: reserved nibbles forced low.
  function automatic logic [15:0] store(input int r, input logic [15:0] d);
    case (r)
      0, 2: return d;
      1:    return {d[15:4], 4'h0};
      3:    return {8'h00, d[7:0]};
      4:    return {d[15:12], 4'h0, d[7:0]};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] lvl_of(input int s);
    logic [15:0] w = mdl[s / 4];
    return w[15 - 4*(s % 4) -: 4];
  endfunction

  // Search from the top level down; first index found at a level wins.
  function automatic logic [9:0] expect_out(input logic [19:0] rq, input logic [3:0] m);
    for (int l = 15; l > m; l--)
      for (int s = 0; s < 20; s++)
        if (rq[s] && lvl_of(s) == 4'(l)) return {1'b1, 5'(s), 4'(l)};
    return 10'h0;
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = d;
    tick();
    bus_we = 1'b0;
    if (a < 5) mdl[a] = store(a, d);
  endtask

  function automatic logic [9:0] outs();
    return {irq_valid, irq_src, irq_lvl};
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] e;
    por_n = 0; man_rst = 0; hw_stby = 0; sw_stby = 0;
    bus_addr = 0; bus_we = 0; bus_wdata = 0; req = '0; cpu_mask = 0;
    for (int r = 0; r < 5; r++) mdl[r] = 16'h0;
    #45; por_n = 1;
    tick();
    // R4 / R9 reset state
    chk("R4 outputs after power-on", 32'(outs()), 0);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      chk("R4 register cleared", 32'(bus_rdata), 0);
    end
    // R1 read/write and R2 reserved nibbles
    for (int a = 0; a < 5; a++) wr(a, 16'hFFFF);
    for (int a = 0; a < 5; a++) begin
      bus_addr = 3'(a); #1;
      chk("R2 reserved read zero", 32'(bus_rdata), 32'(store(a, 16'hFFFF)));
    end
    wr(2, 16'h1234);
    bus_addr = 2; #1;
    chk("R1 readback", 32'(bus_rdata), 32'h1234);
    // R3 unmapped
    wr(5, 16'hABCD); wr(7, 16'h5555);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      chk("R3 unmapped write left bank", 32'(bus_rdata), 32'(a < 5 ? mdl[a] : 16'h0));
    end
    // R8 tie and R6 zero masking
    for (int a = 0; a < 5; a++) wr(a, 16'h0);
    wr(0, 16'h0550);                      // src1=5, src2=5, src0=0
    req = 20'h7; cpu_mask = 0;
    tick();
    chk("R8 tie to lower index", 32'(outs()), 32'({1'b1, 5'd1, 4'd5}));
    req = 20'h1;
    tick();
    chk("R6 level zero never wins", 32'(outs()), 0);
    // R7 strict mask
    req = 20'h2; cpu_mask = 5;
    tick();
    chk("R7 level equal to mask blocked", 32'(outs()), 0);
    cpu_mask = 4;
    tick();
    chk("R7 level above mask forwarded", 32'(outs()), 32'({1'b1, 5'd1, 4'd5}));
    // R9 latency: change before edge, not visible until the edge
    wr(4, 16'hF000);                      // src16 = 15
    req = 20'h10002; #3;
    chk("R9 output before edge unchanged", 32'(outs()), 32'({1'b1, 5'd1, 4'd5}));
    tick();
    chk("R9 output after edge", 32'(outs()), 32'({1'b1, 5'd16, 4'd15}));
    // R5 software standby holds
    sw_stby = 1; req = 20'h0;
    bus_addr = 4; bus_we = 1; bus_wdata = 16'h1111;
    tick(); tick();
    bus_we = 0; #1;
    chk("R5 output held", 32'(outs()), 32'({1'b1, 5'd16, 4'd15}));
    chk("R5 register kept, write ignored", 32'(bus_rdata), 32'hF000);
    sw_stby = 0;
    tick();
    chk("R5 released output updates", 32'(outs()), 0);
    // R4 manual reset and hardware standby
    req = 20'h10000;
    tick();
    man_rst = 1; tick(); man_rst = 0; #1;
    chk("R4 manual reset outputs", 32'(outs()), 0);
    chk("R4 manual reset register", 32'(bus_rdata), 0);
    for (int r = 0; r < 5; r++) mdl[r] = 16'h0;
    wr(0, 16'h9000);
    hw_stby = 1; tick(); hw_stby = 0;
    bus_addr = 0; #1;
    chk("R4 hardware standby register", 32'(bus_rdata), 0);
    mdl[0] = 16'h0;
    // R4 asynchronous power-on clear
    wr(0, 16'h7000);
    #3; por_n = 0; #2;
    bus_addr = 0; #1;
    chk("R4 asynchronous clear", 32'(bus_rdata), 0);
    mdl[0] = 16'h0;
    @(negedge clk); por_n = 1;
    tick();
    // Random mix: R1 R7 R8 R9 against the model
    void'($urandom(32'd1234));
    for (int it = 0; it < 3000; it++) begin
      int a;
      req = 20'($urandom);
      cpu_mask = 4'($urandom_range(0, 6));
      bus_we = ($urandom_range(0, 3) == 0);
      a = $urandom_range(0, 7);
      bus_addr = 3'(a);
      bus_wdata = 16'($urandom);
      e = expect_out(req, cpu_mask);
      if (bus_we && a < 5) mdl[a] = store(a, bus_wdata);
      tick();
      chk("R8 random arbitration", 32'(outs()), 32'(e));
    end
    bus_we = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule